// File: doc/BRIEF.md
# MSI Capture Ring Controller

This block turns inbound message-signalled interrupt writes into entries of a circular buffer in system memory. Each accepted MSI word becomes one 16-byte slot written through a memory write port. Hardware owns the write offset; software drains entries and reports progress by writing the read offset back. While unread entries remain and interrupts are enabled, an interrupt line stays high.

The buffer is described by a 64-bit base address, split across two 32-bit registers, and a 2-bit size code. The size code selects 32 KiB shifted left by the code. Control bits enable capture, full detection, the interrupt, and dropping on full. When the buffer is full and dropping is not selected, the block overwrites the oldest entry and pushes the read offset forward itself. Software clears the enable bit to stop capture, for example before a restart.

Top module: `msi_ring_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq_o` is low and `mem_wr_o` is low.
- R2: Register addresses are: control 0, base-high 1, base-low 2, read offset 3, write offset 4. Base registers read back exactly as written. Control bits are: enable 0, full-detect 1, irq-enable 3, stop-on-full 4, size code 8:7, sticky overflow 16. All other control bits read 0.
- R3: One cycle after an accepted MSI, `mem_wr_o` pulses for one cycle. `mem_addr_o` then equals the base (base-high in bits 63:32, base-low in bits 31:0, low 4 bits forced to 0) plus the write offset held before the capture.
- R4: `mem_wdata_o` is a 128-bit slot. Bits 31:0 hold the MSI word in little-endian byte lanes, so byte 0 sits in bits 7:0 and the vector number in bits 15:0. Bits 127:32 are 0.
- R5: Each capture advances the write offset by 0x10, modulo (32 KiB << size code).
- R6: Software writes to the write-offset register have no effect.
- R7: A software write to the read offset stores the value masked to the buffer size, with bits 3:0 cleared.
- R8: `irq_o` is high exactly when enable and irq-enable are set and the read offset differs from the write offset.
- R9: With enable clear, an MSI issues no memory write and leaves both offsets unchanged.
- R10: The buffer is full when full-detect is set and the advanced write offset would equal the read offset. In that state, with stop-on-full set, the MSI is dropped and the overflow bit is set. The overflow bit stays set until a control write with bit 16 set clears it.
- R11: When full and stop-on-full is clear, the MSI is written, and both offsets advance by 0x10. With full-detect clear, the write offset advances and the read offset is never moved by hardware.
- R12: `reg_rdata_o` shows the register addressed during `reg_rd_i`, starting one cycle later, and holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| msi_valid_i | input | 1 | Inbound MSI write strobe |
| msi_data_i | input | 32 | Inbound MSI data word |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 64 | Memory byte address of the slot |
| mem_wdata_o | output | 128 | Slot contents |
| irq_o | output | 1 | Unread-entries interrupt |

## Verification
An accepted MSI shows up on the memory port on the first rising edge after the strobe is sampled. The offsets, the overflow flag and `irq_o` change at that same edge, while register read data appears one edge after the read strobe. The bench drives every input on the falling edge and samples on the next falling edge, so each result is checked half a period after the single register stage that produces it. A reference model in the bench tracks the offsets and flags and is updated only after each check.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;
  localparam int SIZE_W = 2;
  localparam int REG_W  = 32;

  typedef enum logic [2:0] {
    RA_CTRL    = 3'd0,
    RA_BASE_HI = 3'd1,
    RA_BASE_LO = 3'd2,
    RA_RD_OFF  = 3'd3,
    RA_WR_OFF  = 3'd4
  } reg_addr_e;

  localparam int CB_EN   = 0;
  localparam int CB_FULL = 1;
  localparam int CB_IRQ  = 3;
  localparam int CB_STOP = 4;
  localparam int CB_SZ   = 7;
  localparam int CB_OVF  = 16;

  typedef struct packed {
    logic [SIZE_W-1:0] size;
    logic              stop_full;
    logic              irq_en;
    logic              full_det;
    logic              enable;
  } ctrl_t;
endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
  import msi_ring_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int OFF_W  = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  input  logic              ovf_set_i,
  output ctrl_t             ctrl_o,
  output logic [63:0]       base_o,
  output logic              sw_rd_we_o
);
  ctrl_t            ctrl_q;
  logic [REG_W-1:0] base_hi_q, base_lo_q, rdata_q, rd_mux;
  logic             ovf_q, ctrl_we, ovf_clr;

  assign ctrl_we = reg_wr_i && (reg_addr_i == ADDR_W'(RA_CTRL));
  assign ovf_clr = ctrl_we && reg_wdata_i[CB_OVF];
  assign sw_rd_we_o = reg_wr_i && (reg_addr_i == ADDR_W'(RA_RD_OFF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      base_hi_q <= '0;
      base_lo_q <= '0;
      ovf_q     <= 1'b0;
    end else begin
      if (ctrl_we) begin
        ctrl_q.enable    <= reg_wdata_i[CB_EN];
        ctrl_q.full_det  <= reg_wdata_i[CB_FULL];
        ctrl_q.irq_en    <= reg_wdata_i[CB_IRQ];
        ctrl_q.stop_full <= reg_wdata_i[CB_STOP];
        ctrl_q.size      <= reg_wdata_i[CB_SZ +: SIZE_W];
      end
      if (reg_wr_i && reg_addr_i == ADDR_W'(RA_BASE_HI)) base_hi_q <= reg_wdata_i;
      if (reg_wr_i && reg_addr_i == ADDR_W'(RA_BASE_LO)) base_lo_q <= reg_wdata_i;
      // a drop in the same cycle as a clear wins
      if (ovf_set_i)    ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr_i)
      ADDR_W'(RA_CTRL): begin
        rd_mux[CB_EN]            = ctrl_q.enable;
        rd_mux[CB_FULL]          = ctrl_q.full_det;
        rd_mux[CB_IRQ]           = ctrl_q.irq_en;
        rd_mux[CB_STOP]          = ctrl_q.stop_full;
        rd_mux[CB_SZ +: SIZE_W]  = ctrl_q.size;
        rd_mux[CB_OVF]           = ovf_q;
      end
      ADDR_W'(RA_BASE_HI): rd_mux = base_hi_q;
      ADDR_W'(RA_BASE_LO): rd_mux = base_lo_q;
      ADDR_W'(RA_RD_OFF):  rd_mux = REG_W'(rd_off_i);
      ADDR_W'(RA_WR_OFF):  rd_mux = REG_W'(wr_off_i);
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
  assign ctrl_o      = ctrl_q;
  assign base_o      = {base_hi_q, base_lo_q};

  a_r10_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr) |=> ovf_q);
endmodule

// File: rtl/msi_ring_ptr.sv
module msi_ring_ptr
  import msi_ring_pkg::*;
#(
  parameter int OFF_W    = 18,
  parameter int SLOT_LOG = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic             msi_valid_i,
  input  logic             sw_rd_we_i,
  input  logic [REG_W-1:0] sw_rd_val_i,
  output logic [OFF_W-1:0] wr_off_o,
  output logic [OFF_W-1:0] rd_off_o,
  output logic             take_o,
  output logic             ovf_set_o
);
  localparam int NSIZE = 1 << SIZE_W;
  localparam logic [OFF_W-1:0] SLOT_STEP = OFF_W'(1 << SLOT_LOG);
  localparam logic [OFF_W-1:0] ALL_ONES  = '1;

  logic [OFF_W-1:0] wr_q, rd_q, wr_nxt, rd_nxt, size_mask, slot_mask;
  logic             full, drop, push_rd;

  assign size_mask = ALL_ONES >> (SIZE_W'(NSIZE - 1) - ctrl_i.size);
  assign slot_mask = size_mask & ~(SLOT_STEP - OFF_W'(1));
  assign wr_nxt    = (wr_q + SLOT_STEP) & size_mask;
  assign rd_nxt    = (rd_q + SLOT_STEP) & size_mask;

  assign full    = ctrl_i.full_det && (wr_nxt == rd_q);
  assign drop    = ctrl_i.enable && msi_valid_i && full && ctrl_i.stop_full;
  assign take_o  = ctrl_i.enable && msi_valid_i && !drop;
  assign push_rd = take_o && full;
  assign ovf_set_o = drop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (take_o) wr_q <= wr_nxt;
      // software update has priority over hardware overwrite push
      if (sw_rd_we_i)   rd_q <= sw_rd_val_i[OFF_W-1:0] & slot_mask;
      else if (push_rd) rd_q <= rd_nxt;
    end
  end

  assign wr_off_o = wr_q;
  assign rd_off_o = rd_q;

  a_r9_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.enable |=> $stable(wr_q));
  a_r10_drop_holds_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> $stable(wr_q));
  a_r11_overwrite_moves_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_rd && !sw_rd_we_i) |=> (rd_q != $past(rd_q)));
  a_r7_rd_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rd_we_i |=> (rd_q[SLOT_LOG-1:0] == '0));
endmodule

// File: rtl/msi_ring_wr.sv
module msi_ring_wr
  import msi_ring_pkg::*;
#(
  parameter int OFF_W    = 18,
  parameter int SLOT_LOG = 4,
  parameter int ENTRY_W  = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic [63:0]        base_i,
  input  logic [OFF_W-1:0]   wr_off_i,
  input  logic [REG_W-1:0]   msi_data_i,
  output logic               mem_wr_o,
  output logic [63:0]        mem_addr_o,
  output logic [ENTRY_W-1:0] mem_wdata_o
);
  logic [63:0] base_al;

  assign base_al = {base_i[63:SLOT_LOG], SLOT_LOG'(0)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_wr_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_wr_o <= take_i;
      if (take_i) begin
        mem_addr_o  <= base_al + 64'(wr_off_i);
        mem_wdata_o <= ENTRY_W'(msi_data_i);
      end
    end
  end

  a_r4_slot_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_wdata_o[ENTRY_W-1:REG_W] == '0));
endmodule

// File: rtl/msi_ring_ctrl.sv
module msi_ring_ctrl
  import msi_ring_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int BASE_LOG = 15,
  parameter int SLOT_LOG = 4,
  localparam int OFF_W   = BASE_LOG + (1 << SIZE_W) - 1,
  localparam int ENTRY_W = 8 << SLOT_LOG
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic               msi_valid_i,
  input  logic [31:0]        msi_data_i,
  output logic               mem_wr_o,
  output logic [63:0]        mem_addr_o,
  output logic [ENTRY_W-1:0] mem_wdata_o,
  output logic               irq_o
);
  ctrl_t            ctrl;
  logic [63:0]      base;
  logic [OFF_W-1:0] wr_off, rd_off;
  logic             sw_rd_we, take, ovf_set;

  msi_ring_regs #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_regs (
    .clk_i, .rst_ni, .reg_addr_i, .reg_wr_i, .reg_rd_i, .reg_wdata_i, .reg_rdata_o,
    .wr_off_i(wr_off), .rd_off_i(rd_off), .ovf_set_i(ovf_set),
    .ctrl_o(ctrl), .base_o(base), .sw_rd_we_o(sw_rd_we)
  );

  msi_ring_ptr #(.OFF_W(OFF_W), .SLOT_LOG(SLOT_LOG)) u_ptr (
    .clk_i, .rst_ni, .ctrl_i(ctrl), .msi_valid_i,
    .sw_rd_we_i(sw_rd_we), .sw_rd_val_i(reg_wdata_i),
    .wr_off_o(wr_off), .rd_off_o(rd_off), .take_o(take), .ovf_set_o(ovf_set)
  );

  msi_ring_wr #(.OFF_W(OFF_W), .SLOT_LOG(SLOT_LOG), .ENTRY_W(ENTRY_W)) u_wr (
    .clk_i, .rst_ni, .take_i(take), .base_i(base), .wr_off_i(wr_off),
    .msi_data_i, .mem_wr_o, .mem_addr_o, .mem_wdata_o
  );

  assign irq_o = ctrl.enable && ctrl.irq_en && (wr_off != rd_off);

  a_r3_write_follows_msi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> ($past(msi_valid_i) && $past(ctrl.enable)));
  a_r8_irq_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(msi_valid_i) || $past(reg_wr_i)));
endmodule

// File: tb/sim_msi_ring_ctrl.sv
module sim_msi_ring_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic         reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0]  reg_wdata = '0, reg_rdata;
  logic         msi_valid = 1'b0;
  logic [31:0]  msi_data = '0;
  logic         mem_wr;
  logic [63:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         irq;

  int checks = 0, failures = 0;

  logic [31:0] m_ctrl = '0, m_hi = '0, m_lo = '0;
  logic [17:0] m_wr = '0, m_rd = '0;
  logic        m_ovf = 1'b0;

  always #2 clk = ~clk;

  msi_ring_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .msi_valid_i(msi_valid), .msi_data_i(msi_data), .mem_wr_o(mem_wr),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .irq_o(irq)
  );

  function automatic logic [17:0] fmask(input logic [1:0] s);
    return 18'h3FFFF >> (2'd3 - s);
  endfunction

  function automatic logic [31:0] ctrl_rb();
    return (m_ctrl & 32'h19B) | {15'b0, m_ovf, 16'b0};
  endfunction

  function automatic logic exp_irq();
    return m_ctrl[0] && m_ctrl[3] && (m_wr != m_rd);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic sw_ctrl(input logic [31:0] d);
    reg_write(3'd0, d);
    m_ctrl = d & 32'h19B;
    if (d[16]) m_ovf = 1'b0;
    check(irq == exp_irq(), "R8 irq after control write", 128'(irq), 128'(exp_irq()));
  endtask

  task automatic sw_rd(input logic [31:0] d);
    reg_write(3'd3, d);
    m_rd = d[17:0] & fmask(m_ctrl[8:7]) & ~18'hF;
    check(irq == exp_irq(), "R8 irq after read-offset write", 128'(irq), 128'(exp_irq()));
  endtask

  task automatic check_offsets(input string tag);
    logic [31:0] v;
    reg_read(3'd4, v);
    check(v == 32'(m_wr), {tag, " write offset"}, 128'(v), 128'(m_wr));
    reg_read(3'd3, v);
    check(v == 32'(m_rd), {tag, " read offset"}, 128'(v), 128'(m_rd));
  endtask

  task automatic send_msi(input logic [31:0] d);
    logic [17:0] mask, nxt;
    logic        full, take, push;
    logic [63:0] ea;
    mask = fmask(m_ctrl[8:7]);
    nxt  = (m_wr + 18'h10) & mask;
    full = m_ctrl[1] && (nxt == m_rd);
    take = m_ctrl[0] && !(full && m_ctrl[4]);
    push = take && full;
    ea   = {m_hi, m_lo[31:4], 4'h0} + 64'(m_wr);
    msi_data = d; msi_valid = 1'b1;
    @(negedge clk);
    msi_valid = 1'b0;
    check(mem_wr == take, "R3/R9/R10 memory write strobe", 128'(mem_wr), 128'(take));
    if (take) begin
      check(mem_addr == ea, "R3 slot address", 128'(mem_addr), 128'(ea));
      check(mem_wdata == 128'(d), "R4 slot data", mem_wdata, 128'(d));
      check(mem_wdata[15:0] == d[15:0], "R4 vector lanes", 128'(mem_wdata[15:0]), 128'(d[15:0]));
      m_wr = nxt;
      if (push) m_rd = (m_rd + 18'h10) & mask;
    end else if (m_ctrl[0]) begin
      m_ovf = 1'b1;
    end
    check(irq == exp_irq(), "R8 irq after capture", 128'(irq), 128'(exp_irq()));
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(irq == 1'b0, "R1 irq after reset", 128'(irq), 0);
    check(mem_wr == 1'b0, "R1 mem write after reset", 128'(mem_wr), 0);
    for (int a = 0; a < 5; a++) begin
      reg_read(3'(a), v);
      check(v == 32'd0, "R1 register after reset", 128'(v), 0);
    end

    // R2 register map
    reg_write(3'd1, 32'h0000_0012); m_hi = 32'h0000_0012;
    reg_write(3'd2, 32'h8000_0007); m_lo = 32'h8000_0007;
    reg_read(3'd2, v);
    check(v == m_lo, "R2 base-low readback", 128'(v), 128'(m_lo));
    reg_read(3'd1, v);
    check(v == m_hi, "R2 base-high readback", 128'(v), 128'(m_hi));
    sw_ctrl(32'hFFFE_FE6B);
    reg_read(3'd0, v);
    check(v == ctrl_rb(), "R2 control readback", 128'(v), 128'(ctrl_rb()));
    sw_ctrl(32'h0000_000B);

    // R12 read data holds without strobe
    reg_read(3'd0, v);
    reg_addr = 3'd1;
    @(negedge clk);
    check(reg_rdata == v, "R12 read data hold", 128'(reg_rdata), 128'(v));

    // R3/R4/R5/R8 basic capture
    for (int i = 0; i < 5; i++) send_msi($urandom);
    check_offsets("R5 after five captures");

    // R6 write-offset register ignores writes
    reg_write(3'd4, 32'h0000_1230);
    check_offsets("R6 after write-offset write");

    // R7 read-offset masking and alignment
    sw_rd(32'h0000_0057);
    check_offsets("R7 aligned read offset");
    sw_rd(32'h0001_2345);
    check_offsets("R7 masked read offset");
    sw_rd(32'(m_wr));
    check(irq == 1'b0, "R8 irq low when drained", 128'(irq), 0);

    // R9 disabled capture
    sw_ctrl(32'h0000_000A);
    send_msi(32'hDEAD_0001);
    check(mem_wr == 1'b0, "R9 no write while disabled", 128'(mem_wr), 0);
    check_offsets("R9 offsets while disabled");

    // R10 stop-on-full fills then drops
    sw_ctrl(32'h0000_001B);
    for (int i = 0; i < 2047; i++) send_msi($urandom);
    send_msi(32'hBEEF_0042);
    check(mem_wr == 1'b0, "R10 drop when full", 128'(mem_wr), 0);
    reg_read(3'd0, v);
    check(v[16] == 1'b1, "R10 overflow flag set", 128'(v), 128'(ctrl_rb()));
    sw_ctrl(32'h0000_000B);
    reg_read(3'd0, v);
    check(v == ctrl_rb(), "R10 overflow kept without clear bit", 128'(v), 128'(ctrl_rb()));
    sw_ctrl(32'h0001_000B);
    reg_read(3'd0, v);
    check(v[16] == 1'b0, "R10 overflow cleared", 128'(v), 128'(ctrl_rb()));

    // R11 overwrite oldest pushes read offset
    send_msi(32'h1111_2222);
    check_offsets("R11 overwrite");

    // R11/R5 no full detect: wraps past read offset
    sw_ctrl(32'h0000_0009);
    for (int i = 0; i < 2100; i++) send_msi($urandom);
    check_offsets("R5 wrap at 32 KiB");

    // R5 larger size code
    sw_ctrl(32'h0000_0089);
    for (int i = 0; i < 4200; i++) send_msi($urandom);
    check_offsets("R5 wrap at 64 KiB");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 6) send_msi($urandom);
      else if (op == 6) sw_rd($urandom);
      else if (op == 7) sw_ctrl(($urandom & 32'h0001_019B) | 32'h1);
      else if (op == 8) check_offsets("R5/R7 random");
      else begin
        reg_read(3'd0, v);
        check(v == ctrl_rb(), "R2/R10 random control", 128'(v), 128'(ctrl_rb()));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule